// File: doc/BRIEF.md
# Receive Character Store and Event Controller

This block sits between an asynchronous serial receiver and the consumer of the received characters. Each received character comes in with its data byte, its received parity bit and two error flags (parity error and framing error). The block builds a 16-bit entry from these and writes it into a first-word-fall-through FIFO of parameterised depth. Two configuration inputs decide what goes into the upper byte of an entry: one enables keeping the received parity bit, the other enables keeping the per-character error status.

Besides storing data, the block produces event outputs. A fill-level event stays high while the FIFO holds at least a programmed number of entries. A one-cycle pulse marks the arrival of a programmable termination character. A one-cycle idle pulse fires once a programmed number of idle cycles has passed since the last character, provided data is waiting. Every character flagged with a parity or framing error also gives a one-cycle pulse. A sticky flag records any character that was lost because the FIFO was full.

Top module: `rx_fifo_evt_ctrl`

## Requirements
- R1: An entry carries the character's data in bits 7:0. Bit 8 holds the received parity bit when cfg_par_store is 1 and is 0 otherwise.
- R2: When cfg_stat_store is 1, bit 9 of an entry holds the parity error flag and bit 10 holds the framing error flag. When cfg_stat_store is 0, both bits are 0. Bits 15:11 are always 0.
- R3: Entries are read out in arrival order. rd_data shows the oldest entry while rd_empty is 0, and a rd_en pulse removes it at the clock edge. fill_count gives the number of stored entries. rd_en has no effect while the FIFO is empty.
- R4: A character that arrives while fill_count equals DEPTH is dropped and leaves the stored entries unchanged. ovf_flag is set from the next cycle and stays set until reset. A read in the same cycle does not make room for the incoming character.
- R5: evt_thresh is high whenever cfg_thresh is nonzero and fill_count is at least cfg_thresh.
- R6: When cfg_term_en is 1 and a stored character's data bits equal cfg_term_char, evt_term is high for exactly the one cycle after the write. By that cycle the entry is already counted in fill_count. The parity and error bits are not compared. Dropped characters raise no event.
- R7: After a character is accepted on the interface, evt_idle pulses for one cycle once cfg_idle_limit cycles without a character have passed, counting the edge that raises the pulse, and only if the FIFO was non-empty on that edge. It fires at most once per idle period. A new character restarts the count. Nothing fires before the first character after reset, or while cfg_idle_limit is 0.
- R8: evt_par_err and evt_frm_err pulse for one cycle after any character that carries the matching error flag, whatever the storage options and whether the character was stored or dropped.
- R9: After reset the FIFO is empty, fill_count is 0, and every event output and ovf_flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | A received character is present this cycle |
| char_data | input | 8 | Received data byte |
| char_parity | input | 1 | Received parity bit |
| char_par_err | input | 1 | Parity error flag of the character |
| char_frm_err | input | 1 | Framing error flag of the character |
| cfg_par_store | input | 1 | Keep the parity bit in entry bit 8 |
| cfg_stat_store | input | 1 | Keep the error flags in entry bits 10:9 |
| cfg_thresh | input | CW | Fill level for evt_thresh, 0 disables it |
| cfg_term_en | input | 1 | Enable termination character detection |
| cfg_term_char | input | 8 | Termination character value |
| cfg_idle_limit | input | TW | Idle cycles before evt_idle, 0 disables it |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | 16 | Oldest entry |
| rd_empty | output | 1 | FIFO holds no entry |
| fill_count | output | CW | Number of stored entries |
| evt_thresh | output | 1 | Fill level reached (level) |
| evt_term | output | 1 | Termination character stored (pulse) |
| evt_idle | output | 1 | Idle time-out (pulse) |
| evt_par_err | output | 1 | Character with parity error received (pulse) |
| evt_frm_err | output | 1 | Character with framing error received (pulse) |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The embedded properties assume the configuration inputs change only while no character is in flight. They also assume that char_valid marks at most one character per cycle and that rd_en may be asserted at any time, including into an empty FIFO. The random stimulus keeps to these limits. It changes the configuration only between phases and draws valid and read strobes independently, so reads on an empty FIFO, writes into a full FIFO and accesses that collide with a read all occur. The idle-timer phase uses sparse character arrival, so time-outs fire both with data waiting and with an empty FIFO.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int CHAR_W  = 8;
   localparam int ENTRY_W = 16;

   typedef struct packed {
      logic [CHAR_W-1:0] data;
      logic              parity;
      logic              par_err;
      logic              frm_err;
   } rx_char_t;
endpackage

// File: rtl/rxf_formatter.sv
module rxf_formatter
   import rxf_pkg::*;
#(
   parameter bit STATUS_EN = 1'b1
) (
   input  rx_char_t             chr,
   input  logic                 par_store,
   input  logic                 stat_store,
   output logic [ENTRY_W-1:0]   entry
);
   localparam int HI_W = ENTRY_W - CHAR_W;
   logic [HI_W-1:0] hi;

   generate
      if (STATUS_EN) begin : g_status
         assign hi = {{(HI_W-3){1'b0}},
                      stat_store & chr.frm_err,
                      stat_store & chr.par_err,
                      par_store  & chr.parity};
      end else begin : g_nostatus
         logic unused_st;
         assign unused_st = stat_store ^ chr.frm_err ^ chr.par_err;
         assign hi = {{(HI_W-1){1'b0}}, par_store & chr.parity};
      end
   endgenerate

   assign entry = {hi, chr.data};
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DEPTH = 16,
   parameter int W     = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_req,
   output logic [W-1:0]  rd_data,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          wr_done
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxf_store: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          rd_done;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign wr_done = wr_req & ~full;
   assign rd_done = rd_req & ~empty;
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_done) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (wr_done) wp <= wp + 1'b1;
         if (rd_done) rp <= rp + 1'b1;
         count <= count + CW'(wr_done) - CW'(rd_done);
      end
   end

   assert_full_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && full && !rd_req) |=> $stable(count));
   assert_empty_read_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty && !wr_req) |=> (count == '0));
   always_comb begin
      if (rst_n) assert_count_bound_R3: assert (count <= CW'(DEPTH));
   end
endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          char_seen,
   input  logic          nonempty,
   input  logic [TW-1:0] limit,
   output logic          fire
);
   generate
      if (TW < 1) begin : g_bad_tw
         $error("rxf_idle_timer: TW must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cnt;
   logic          done;
   logic [TW:0]   nxt;

   assign nxt = {1'b0, cnt} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b1;
         fire <= 1'b0;
      end else if (char_seen) begin
         cnt  <= '0;
         done <= 1'b0;
         fire <= 1'b0;
      end else if (!done && limit != '0) begin
         if (nxt == {1'b0, limit}) begin
            done <= 1'b1;
            fire <= nonempty;
         end else begin
            cnt  <= nxt[TW-1:0];
            fire <= 1'b0;
         end
      end else begin
         fire <= 1'b0;
      end
   end

   assert_idle_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   assert_idle_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      char_seen |=> !fire);
endmodule

// File: rtl/rxf_events.sv
module rxf_events
   import rxf_pkg::*;
#(
   parameter int CW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  rx_char_t          chr,
   input  logic              stored,
   input  logic              dropped,
   input  logic              term_en,
   input  logic [CHAR_W-1:0] term_char,
   input  logic [CW-1:0]     thresh,
   input  logic [CW-1:0]     count,
   output logic              evt_thresh,
   output logic              evt_term,
   output logic              evt_par_err,
   output logic              evt_frm_err,
   output logic              ovf
);
   assign evt_thresh = (thresh != '0) && (count >= thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_term    <= 1'b0;
         evt_par_err <= 1'b0;
         evt_frm_err <= 1'b0;
         ovf         <= 1'b0;
      end else begin
         evt_term    <= stored & term_en & (chr.data == term_char);
         evt_par_err <= valid & chr.par_err;
         evt_frm_err <= valid & chr.frm_err;
         if (dropped) ovf <= 1'b1;
      end
   end

   assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_term_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_term |-> (count != '0));
   assert_term_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !term_en |=> !evt_term);
endmodule

// File: rtl/rx_fifo_evt_ctrl.sv
module rx_fifo_evt_ctrl
   import rxf_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int TW        = 16,
   parameter bit STATUS_EN = 1'b1,
   localparam int CW       = $clog2(DEPTH) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               char_valid,
   input  logic [CHAR_W-1:0]  char_data,
   input  logic               char_parity,
   input  logic               char_par_err,
   input  logic               char_frm_err,
   input  logic               cfg_par_store,
   input  logic               cfg_stat_store,
   input  logic [CW-1:0]      cfg_thresh,
   input  logic               cfg_term_en,
   input  logic [CHAR_W-1:0]  cfg_term_char,
   input  logic [TW-1:0]      cfg_idle_limit,
   input  logic               rd_en,
   output logic [ENTRY_W-1:0] rd_data,
   output logic               rd_empty,
   output logic [CW-1:0]      fill_count,
   output logic               evt_thresh,
   output logic               evt_term,
   output logic               evt_idle,
   output logic               evt_par_err,
   output logic               evt_frm_err,
   output logic               ovf_flag
);
   rx_char_t           chr;
   logic [ENTRY_W-1:0] entry;
   logic               full, wr_done;

   assign chr = '{data: char_data, parity: char_parity,
                  par_err: char_par_err, frm_err: char_frm_err};

   rxf_formatter #(.STATUS_EN(STATUS_EN)) u_fmt (
      .chr(chr), .par_store(cfg_par_store), .stat_store(cfg_stat_store),
      .entry(entry));

   rxf_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_req(char_valid), .wr_data(entry),
      .rd_req(rd_en), .rd_data(rd_data), .count(fill_count), .full(full),
      .empty(rd_empty), .wr_done(wr_done));

   rxf_idle_timer #(.TW(TW)) u_idle (
      .clk(clk), .rst_n(rst_n), .char_seen(char_valid), .nonempty(~rd_empty),
      .limit(cfg_idle_limit), .fire(evt_idle));

   rxf_events #(.CW(CW)) u_evt (
      .clk(clk), .rst_n(rst_n), .valid(char_valid), .chr(chr),
      .stored(wr_done), .dropped(char_valid & full),
      .term_en(cfg_term_en), .term_char(cfg_term_char),
      .thresh(cfg_thresh), .count(fill_count),
      .evt_thresh(evt_thresh), .evt_term(evt_term),
      .evt_par_err(evt_par_err), .evt_frm_err(evt_frm_err), .ovf(ovf_flag));

   assert_idle_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_empty && !char_valid) |=> !evt_idle);
   assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !char_valid |=> (!evt_par_err && !evt_frm_err));
endmodule

// File: tb/sim_rx_fifo_evt_ctrl.sv
`timescale 1ns/1ps
module sim_rx_fifo_evt_ctrl;
   localparam int DEPTH = 16;
   localparam int TW    = 16;
   localparam int CW    = $clog2(DEPTH) + 1;

   logic clk = 0, rst_n = 0;
   logic v = 0, p = 0, pe = 0, fe = 0, ps = 0, ss = 0, te = 0, rd = 0;
   logic [7:0] d = 0, tc = 0;
   logic [CW-1:0] thr = 0;
   logic [TW-1:0] lim = 0;
   logic [15:0] rdata;
   logic rempty, e_thr, e_term, e_idle, e_pe, e_fe, ovf;
   logic [CW-1:0] cnt;

   int total = 0, bad = 0;
   bit finished = 0;

   logic [15:0] q[$];
   bit m_ovf = 0, m_fired = 1;
   int m_idle = 0;

   always #2 clk = ~clk;

   rx_fifo_evt_ctrl #(.DEPTH(DEPTH), .TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .char_valid(v), .char_data(d),
      .char_parity(p), .char_par_err(pe), .char_frm_err(fe),
      .cfg_par_store(ps), .cfg_stat_store(ss), .cfg_thresh(thr),
      .cfg_term_en(te), .cfg_term_char(tc), .cfg_idle_limit(lim),
      .rd_en(rd), .rd_data(rdata), .rd_empty(rempty), .fill_count(cnt),
      .evt_thresh(e_thr), .evt_term(e_term), .evt_idle(e_idle),
      .evt_par_err(e_pe), .evt_frm_err(e_fe), .ovf_flag(ovf));

   function automatic logic [15:0] fmt(logic [7:0] dd, logic pp, logic ppe, logic ffe);
      logic [15:0] r;
      r = {8'h00, dd};
      r[8]  = ps & pp;
      r[9]  = ss & ppe;
      r[10] = ss & ffe;
      return r;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(logic iv, logic [7:0] id, logic ip, logic ipe, logic ife, logic ird);
      int sz;
      bit ex_term, ex_idle;
      v = iv; d = id; p = ip; pe = ipe; fe = ife; rd = ird;
      #0.5;
      sz = q.size();
      if (sz > 0) chk("R1/R2/R3 head entry", rdata, q[0]);
      chk("R3 empty before edge", rempty, sz == 0);
      // model of the coming edge
      ex_term = 0; ex_idle = 0;
      if (iv) begin
         m_idle = 0; m_fired = 0;
      end else if (!m_fired && lim != 0) begin
         m_idle++;
         if (m_idle == lim) begin m_fired = 1; ex_idle = (sz > 0); end
      end
      if (iv && sz < DEPTH) ex_term = te && (id == tc);
      if (iv && sz >= DEPTH) m_ovf = 1;
      if (ird && sz > 0) void'(q.pop_front());
      if (iv && sz < DEPTH) q.push_back(fmt(id, ip, ipe, ife));
      @(posedge clk); @(negedge clk);
      chk("R3 fill_count", cnt, q.size());
      chk("R3 rd_empty", rempty, q.size() == 0);
      chk("R4 ovf_flag", ovf, m_ovf);
      chk("R5 evt_thresh", e_thr, (thr != 0) && (q.size() >= thr));
      chk("R6 evt_term", e_term, ex_term);
      chk("R7 evt_idle", e_idle, ex_idle);
      chk("R8 evt_par_err", e_pe, iv & ipe);
      chk("R8 evt_frm_err", e_fe, iv & ife);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      @(negedge clk); @(negedge clk);
      // R9 reset state
      chk("R9 reset empty", rempty, 1);
      chk("R9 reset count", cnt, 0);
      chk("R9 reset events", {e_thr, e_term, e_idle, e_pe, e_fe, ovf}, 0);
      rst_n = 1;
      @(negedge clk);

      // R3 read on empty ignored
      step(0, 0, 0, 0, 0, 1);
      // R1 R2 format under all storage options
      ps = 0; ss = 0; step(1, 8'hA5, 1, 1, 1, 0);
      ps = 1; ss = 0; step(1, 8'h3C, 1, 1, 1, 0);
      ps = 0; ss = 1; step(1, 8'h0F, 1, 1, 0, 0);
      ps = 1; ss = 1; step(1, 8'hF0, 1, 0, 1, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1);
      chk("R3 drained", cnt, 0);

      // R6 termination: match on data only, disabled gives nothing
      te = 1; tc = 8'h0D;
      step(1, 8'h0D, 1, 1, 0, 0);
      step(1, 8'h0A, 0, 0, 0, 0);
      te = 0; step(1, 8'h0D, 0, 0, 0, 0);
      te = 1; idle(1);

      // R4 R5 overflow and threshold
      thr = 8;
      for (int i = 0; i < DEPTH; i++) step(1, 8'(i + 8'h40), 0, 0, 0, 0);
      step(1, 8'h0D, 0, 0, 1, 0);   // dropped: no term event, framing pulse
      step(1, 8'h55, 0, 0, 0, 1);   // read while full still drops
      for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 0, 1);
      chk("R4 ovf stays after drain", ovf, 1);

      // R7 idle timer
      lim = 5;
      step(1, 8'h11, 0, 0, 0, 0);
      idle(9);
      step(1, 8'h12, 0, 0, 0, 0);
      idle(2);
      step(1, 8'h13, 0, 0, 0, 0);
      idle(7);
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1);
      step(1, 8'h14, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1);
      idle(8);                      // empty FIFO: no time-out
      lim = 0; step(1, 8'h15, 0, 0, 0, 0); idle(20);
      for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, 1);

      // constrained random phases
      for (int ph = 0; ph < 6; ph++) begin
         ps  = ph[0]; ss = ph[1];
         thr = CW'($urandom_range(0, DEPTH));
         te  = $urandom_range(0, 1);
         tc  = 8'($urandom_range(0, 7));
         lim = TW'($urandom_range(0, 12));
         for (int i = 0; i < 1500; i++) begin
            int vp, rp;
            vp = (ph < 3) ? 40 : 15;
            rp = (ph == 2) ? 20 : 35;
            step($urandom_range(0, 99) < vp, 8'($urandom_range(0, 15)),
                 $urandom_range(0, 1), $urandom_range(0, 3) == 0,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 99) < rp);
         end
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule